// File: doc/BRIEF.md
# Rate-Matched Byte Link Pair

This block is a transmitter and a receiver for a byte-wide link that moves a byte in every clock cycle, even when the payload it carries arrives at a much slower, emulated rate. Only one slot in every N carries payload. N is read from a configuration input while reset is held, and it then stays fixed. Every other slot carries a filler byte. The filler byte is the value of a counter that steps once per slot. Traffic on the link never stops, so the wires, drivers and receivers see full-rate, changing data all the time. At the same time, the payload each end sees is paced to the emulated rate.

The transmitter and the receiver each run a slot counter and a filler counter, and both are aligned by the shared reset. The receiver passes payload slots to its output with a one-cycle strobe. It compares every filler slot with its own predicted value and keeps a saturating count of mismatches, plus a sticky error flag. The link wires leave the top on the transmit side and come back in on the receive side. The integrator can route, retime-free, or tamper with them.

Payload enters through a valid/ready port. `in_ready` is high only during a payload slot. A source that raises `in_valid` must hold `in_valid` and `in_data` unchanged until a cycle in which `in_ready` is also high, which is when the byte is taken. The output side has no back-pressure: `out_valid` is a single-cycle strobe that cannot be held off, because the link cannot stall.

Top module: `ratematch_link`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `tx_dv`, `out_valid`, `err_count` and `err_sticky` are all 0.
- R2: The spacing N is taken from `cfg_spacing` while `rst_n` is low, with 0 treated as 1. Slot k counts clock edges from 0, starting at the first edge with `rst_n` high. Slot k is a payload slot exactly when k mod N is 0, and `in_ready` is high in exactly those cycles.
- R3: After the edge of a non-payload slot k, `tx_dv` is 0 and `tx_byte` equals k mod 256.
- R4: If `in_valid` and `in_ready` are both high at an edge, then after that edge `tx_dv` is 1 and `tx_byte` is the `in_data` that was taken.
- R5: If a payload slot k passes with `in_valid` low, then after that edge `tx_dv` is 0 and `tx_byte` equals k mod 256.
- R6: A payload byte taken at edge k appears at the output after edge k+1, as `out_valid` high for one cycle with `out_data` equal to the byte. Bytes come out in the order they were taken.
- R7: A payload slot that arrives at the receiver with `rx_dv` low produces no `out_valid`, and is not compared against the filler.
- R8: Each non-payload slot whose `rx_byte` differs from the expected filler raises `err_count` by one and sets `err_sticky`. The flag stays set until reset. Corrupted bytes in payload slots are never counted.
- R9: `err_count` never decreases, and it saturates at its all-ones value.
- R10: Changing `cfg_spacing` while `rst_n` is high has no effect on the slot pattern.
- R11: A byte offered with `in_valid` outside a payload slot is held by the source and taken exactly once, at the next payload slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-rate clock |
| rst_n | input | 1 | Active-low reset shared by both ends; N is captured while it is low |
| cfg_spacing | input | SPC_W | Payload spacing N (0 means 1) |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | DATA_W | Payload byte |
| in_ready | output | 1 | High in payload slots; the byte is taken when in_valid is also high |
| tx_byte | output | DATA_W | Byte driven onto the link |
| tx_dv | output | 1 | Link data-valid bit for payload slots |
| rx_byte | input | DATA_W | Byte received from the link |
| rx_dv | input | 1 | Received data-valid bit |
| out_valid | output | 1 | One-cycle strobe for a delivered payload byte |
| out_data | output | DATA_W | Delivered payload byte |
| err_count | output | ERR_W | Saturating count of filler mismatches |
| err_sticky | output | 1 | Set by the first filler mismatch, cleared only by reset |

## Verification
The assertions rely on the transmit source keeping the back-pressure rule: once `in_valid` is high outside a payload slot, `in_valid` and `in_data` stay unchanged until the byte is taken. They also rely on the receive side seeing the link one register stage behind the transmitter. The bench wires `rx_byte`/`rx_dv` straight to `tx_byte`/`tx_dv`, with at most an XOR mask on the byte. It changes a held payload byte only after the cycle in which it was taken, and it drops `in_valid` only after acceptance or together with a reset.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_SPC_W  = 8;
  localparam int DEF_ERR_W  = 16;

  typedef enum logic {
    SLOT_FILL = 1'b0,
    SLOT_DATA = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/slot_seq.sv
module slot_seq
  import link_pkg::*;
#(
  parameter int SPC_W  = DEF_SPC_W,
  parameter int FILL_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [SPC_W-1:0]  cfg_spacing,
  output slot_kind_e        kind,
  output logic [FILL_W-1:0] fill
);
  localparam logic [SPC_W-1:0] ONE = SPC_W'(1);

  logic [SPC_W-1:0]  spacing_q;
  logic [SPC_W-1:0]  slot_q;
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spacing_q <= (cfg_spacing == '0) ? ONE : cfg_spacing;
      slot_q    <= '0;
      fill_q    <= '0;
    end else if (adv) begin
      slot_q <= (slot_q == spacing_q - ONE) ? '0 : slot_q + ONE;
      fill_q <= fill_q + FILL_W'(1);
    end
  end

  assign kind = (slot_q == '0) ? SLOT_DATA : SLOT_FILL;
  assign fill = fill_q;

  assert_slot_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < spacing_q);
  assert_spacing_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(spacing_q));
  assert_fill_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> fill_q == $past(fill_q) + FILL_W'(1));
endmodule

// File: rtl/link_tx.sv
module link_tx
  import link_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int SPC_W  = DEF_SPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPC_W-1:0]  cfg_spacing,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_dv
);
  slot_kind_e        kind;
  logic [DATA_W-1:0] fill;
  logic              take;

  slot_seq #(.SPC_W(SPC_W), .FILL_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .cfg_spacing(cfg_spacing),
    .kind(kind), .fill(fill)
  );

  assign in_ready = rst_n && (kind == SLOT_DATA);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      tx_dv   <= 1'b0;
    end else begin
      tx_byte <= take ? in_data : fill;
      tx_dv   <= take;
    end
  end

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_dv && tx_byte == $past(in_data)));
  assert_gap_no_dv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !in_ready) |=> !tx_dv);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data)));
endmodule

// File: rtl/link_rx.sv
module link_rx
  import link_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int SPC_W  = DEF_SPC_W,
  parameter int ERR_W  = DEF_ERR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPC_W-1:0]  cfg_spacing,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_dv,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [ERR_W-1:0]  err_count,
  output logic              err_sticky
);
  slot_kind_e        kind;
  logic [DATA_W-1:0] fill;
  logic              primed_q;
  logic              bad_fill;

  slot_seq #(.SPC_W(SPC_W), .FILL_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(primed_q), .cfg_spacing(cfg_spacing),
    .kind(kind), .fill(fill)
  );

  assign bad_fill = primed_q && (kind == SLOT_FILL) && (rx_byte != fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q   <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      err_count  <= '0;
      err_sticky <= 1'b0;
    end else begin
      primed_q  <= 1'b1;
      out_valid <= primed_q && (kind == SLOT_DATA) && rx_dv;
      if (primed_q && (kind == SLOT_DATA) && rx_dv) out_data <= rx_byte;
      if (bad_fill) begin
        err_sticky <= 1'b1;
        if (err_count != '1) err_count <= err_count + ERR_W'(1);
      end
    end
  end

  assert_out_needs_dv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_dv));
  assert_err_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count) || err_count == $past(err_count) + ERR_W'(1)));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != '0) |-> err_sticky);
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

// File: rtl/ratematch_link.sv
module ratematch_link
  import link_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int SPC_W  = DEF_SPC_W,
  parameter int ERR_W  = DEF_ERR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPC_W-1:0]  cfg_spacing,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_dv,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_dv,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [ERR_W-1:0]  err_count,
  output logic              err_sticky
);
  link_tx #(.DATA_W(DATA_W), .SPC_W(SPC_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_spacing(cfg_spacing),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_byte(tx_byte), .tx_dv(tx_dv)
  );

  link_rx #(.DATA_W(DATA_W), .SPC_W(SPC_W), .ERR_W(ERR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_spacing(cfg_spacing),
    .rx_byte(rx_byte), .rx_dv(rx_dv),
    .out_valid(out_valid), .out_data(out_data),
    .err_count(err_count), .err_sticky(err_sticky)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!in_ready && !tx_dv && !out_valid && err_count == '0 && !err_sticky));
endmodule

// File: tb/tb_ratematch_link.sv
module tb_ratematch_link;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int SW = 8;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] cfg_spacing = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [DW-1:0] tx_byte, rx_byte, out_data;
  logic          tx_dv, out_valid, err_sticky;
  logic [EW-1:0] err_count;
  logic [DW-1:0] mask = '0;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  assign rx_byte = tx_byte ^ mask;

  ratematch_link #(.DATA_W(DW), .SPC_W(SW), .ERR_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_spacing(cfg_spacing),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_byte(tx_byte), .tx_dv(tx_dv),
    .rx_byte(rx_byte), .rx_dv(tx_dv),
    .out_valid(out_valid), .out_data(out_data),
    .err_count(err_count), .err_sticky(err_sticky)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input int n);
    rst_n = 1'b0;
    in_valid = 1'b0;
    mask = '0;
    cfg_spacing = SW'(n);
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  // Drives a stream for a number of slots and checks ready, link and output.
  task automatic run_stream(input int n_eff, input int cycles, input bit feed, input int base);
    int k = 0;
    int idx = 0;
    bit acc_prev = 1'b0;
    logic [DW-1:0] dat_prev = '0;
    for (int i = 0; i < cycles; i++) begin
      bit exp_ready = ((k % n_eff) == 0);
      bit acc;
      logic [DW-1:0] dat;
      in_valid = feed;
      in_data = DW'(base + idx * 7);
      #1;
      chk(in_ready == exp_ready, "R2 ready", int'(in_ready), int'(exp_ready));
      acc = feed && exp_ready;
      dat = in_data;
      step();
      chk(tx_dv == acc, acc ? "R4 dv" : "R3/R5 dv", int'(tx_dv), int'(acc));
      chk(tx_byte == (acc ? dat : DW'(k)), acc ? "R4 byte" : "R3/R5 filler",
          int'(tx_byte), acc ? int'(dat) : (k % 256));
      chk(out_valid == acc_prev, "R6/R7 out_valid", int'(out_valid), int'(acc_prev));
      if (acc_prev) chk(out_data == dat_prev, "R6 out_data", int'(out_data), int'(dat_prev));
      acc_prev = acc;
      dat_prev = dat;
      if (acc) idx++;
      k++;
    end
    chk(err_count == 0, "R8 clean link", int'(err_count), 0);
  endtask

  task automatic t_reset();
    do_reset(4);
    rst_n = 1'b0;
    #1;
    chk(!in_ready && !tx_dv && !out_valid, "R1 outputs", int'({in_ready, tx_dv, out_valid}), 0);
    chk(err_count == 0 && !err_sticky, "R1 errors", int'(err_count), 0);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R2 first slot", int'(in_ready), 1);
  endtask

  task automatic t_spacing4();
    do_reset(4);
    run_stream(4, 60, 1'b1, 8'h31);   // R11 held bytes taken once
  endtask

  task automatic t_zero_is_one();
    do_reset(0);
    run_stream(1, 40, 1'b1, 8'hC2);
  endtask

  task automatic t_idle();
    do_reset(3);
    run_stream(3, 30, 1'b0, 0);       // R5 and R7: no payload
  endtask

  task automatic t_cfg_frozen();
    do_reset(3);
    cfg_spacing = 8'd5;               // R10
    run_stream(3, 300, 1'b1, 8'h05);  // also covers filler wrap past 255
  endtask

  task automatic t_errors();
    do_reset(4);
    step(); step();                   // link carries slot 1 (filler)
    mask = 8'h5A;
    step();
    mask = '0;
    chk(err_count == 1, "R8 filler mismatch count", int'(err_count), 1);
    chk(err_sticky == 1'b1, "R8 sticky set", int'(err_sticky), 1);
    step(); step();                   // link carries slot 4 (payload, dv low)
    mask = 8'hFF;
    step();
    mask = '0;
    chk(out_valid == 1'b0, "R7 dropped slot", int'(out_valid), 0);
    chk(err_count == 1, "R7 not compared", int'(err_count), 1);
    step(); step();                   // slot 8 presented
    in_valid = 1'b1;
    in_data = 8'h77;
    step();                           // taken, link carries slot 8
    in_valid = 1'b0;
    mask = 8'h0F;
    step();
    mask = '0;
    chk(out_valid == 1'b1 && out_data == 8'h78, "R8 payload corrupt passes", int'(out_data), 8'h78);
    chk(err_count == 1, "R8 payload not counted", int'(err_count), 1);
    repeat (8) step();
    chk(err_sticky == 1'b1 && err_count == 1, "R8 sticky holds", int'(err_count), 1);
  endtask

  task automatic t_saturate();
    do_reset(2);
    mask = 8'hFF;
    repeat (21) step();
    chk(err_count == 10, "R8 one per bad filler", int'(err_count), 10);
    repeat (30) step();
    chk(err_count == 15, "R9 saturation", int'(err_count), 15);
    mask = '0;
    repeat (4) step();
    chk(err_count == 15, "R9 no decrease", int'(err_count), 15);
  endtask

  initial begin
    t_reset();
    t_spacing4();
    t_zero_is_one();
    t_idle();
    t_cfg_frozen();
    t_errors();
    t_saturate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule